// File: doc/BRIEF.md
# Interval Timer with Standby-Wake Settling

This block is an 8-bit up-counter that is clocked through a selectable power-of-two prescaler and has two uses. In normal running, with the timer enabled and the mode bit at 0, it issues a one-cycle interrupt pulse each time the count wraps from 0xFF to 0x00. Each pulse also sets a sticky status flag, which software clears.

The same counter serves as the oscillator settling timer for a low-power standby state. Software may enter standby only after it has disabled the timer. On entry the count and the prescaler are cleared, and the clock-select value in force at that moment is captured. A wake event (the non-maskable line or any of the four interrupt lines) starts settling. The counter then runs at the captured rate. When it wraps, the block raises a one-cycle clock-release pulse and leaves standby. No interval interrupt is raised for this wrap.

The control fields arrive as plain inputs from an external register. The current count is brought out so that software can read it.

Top module: `tick_wake_timer`

## Requirements
- R1: After reset the count is 0x00, int_pulse, int_flag and clk_release are 0, and sby_active is 0.
- R2: While counting, the count rises by one every 2^(clk_sel+1) clocks, with clk_sel from 0 to 7 giving divisions 2 to 256. The first increment comes a full division after counting starts.
- R3: With tmr_en=1 and tmr_mode=0, a wrap from 0xFF to 0x00 gives int_pulse high for exactly one cycle, in the same cycle that count_o first reads 0x00.
- R4: int_flag becomes 1 together with int_pulse and stays 1 until a cycle with flag_clr=1. If a set and a clear fall on the same edge, the set wins.
- R5: While tmr_en=0, count_o holds its value and the prescaler is cleared. After re-enabling, the next increment comes a full division later.
- R6: With tmr_mode=1 the count holds and no interrupt is raised.
- R7: A standby request made while tmr_en=1 is refused: sby_active stays 0 and counting continues.
- R8: A standby request made with tmr_en=0 sets sby_active on the next cycle, and count_o then reads 0x00.
- R9: The count does not advance in standby before a wake event. Wake inputs have no effect outside standby, and a standby request has no effect while already in standby.
- R10: Settling counts at the clk_sel value captured when standby was entered. Later changes to clk_sel have no effect. The release comes 256 × division clocks after the edge that samples the wake event.
- R11: At the settling wrap, clk_release pulses for one cycle, sby_active falls in that same cycle, and neither int_pulse nor int_flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_en | input | 1 | Timer enable bit |
| tmr_mode | input | 1 | Mode bit; 0 selects interval operation |
| clk_sel | input | 3 | Prescaler select; division is 2^(clk_sel+1) |
| flag_clr | input | 1 | Clears the interrupt status flag |
| sby_req | input | 1 | Request to enter standby |
| wake_nmi | input | 1 | Non-maskable wake line |
| wake_irq | input | 4 | Four maskable wake lines |
| count_o | output | 8 | Current count value |
| int_pulse | output | 1 | One-cycle interval interrupt |
| int_flag | output | 1 | Sticky interrupt status |
| sby_active | output | 1 | Standby (sleep or settling) in progress |
| clk_release | output | 1 | One-cycle pulse that ends standby |

## Verification
An interval wrap that sets the status flag can fall on the same edge as a software clear of that flag. The bench provokes this by holding flag_clr high during exactly the cycle whose closing edge carries the second wrap. It judges the result by expecting the flag still set afterwards (set wins), and then by expecting a lone clear to drop the flag. Interrupt and release pulses are checked by the scoreboard against the exact cycle computed from the division and the start edge. Any pulse for which no entry is queued counts as a failure, which catches an interrupt raised during settling.

// File: rtl/twt_pkg.sv
// Package: shared types for the interval/settling timer.
// Assumes: three operating states are enough to describe standby handling.
package twt_pkg;

    // Operating state of the block.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,   // normal operation, counter may run in interval mode
        ST_SLEEP  = 2'd1,   // standby, oscillator stopped, waiting for a wake event
        ST_SETTLE = 2'd2    // standby, oscillator restarting, counting settle time
    } twt_state_e;

endpackage

// File: rtl/twt_prescaler.sv
// Module: power-of-two prescaler producing a one-cycle count enable.
// Behaviour: while run is high, a free counter advances; tick is high when
//            its low (sel+1) bits are all ones, i.e. every 2^(sel+1) clocks.
// Assumes: the counter restarts from zero whenever run is low.
module twt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 2 ** SEL_W;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    // Build the low-bit mask: bit i is set when i <= sel.
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
        assign mask[gi] = (gi <= int'(sel));
    end

    // Tick when all selected low bits of the prescaler are ones.
    assign tick = run && ((pre & mask) == mask);

    // Advance the prescaler while running, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (run) begin
            pre <= pre + PRE_W'(1);
        end else begin
            pre <= '0;
        end
    end

    // Division is at least two, so two ticks never come back to back.
    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/twt_counter.sv
// Module: up-counter with synchronous clear and a wrap strobe.
// Behaviour: clear wins over step; wrap is high on a step taken at all-ones.
// Assumes: step is a single-cycle enable from the prescaler.
module twt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Flag the step that takes the count from all-ones back to zero.
    assign wrap = step && (count == CNT_MAX);

    // Hold, clear or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end

    assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(count));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

endmodule

// File: rtl/twt_standby_fsm.sv
// Module: standby sequencer (run -> sleep -> settle -> run).
// Behaviour: a request is accepted only from run with the timer disabled;
//            a wake event starts settling; the settling wrap returns to run.
// Assumes: settle_wrap is only meaningful in the settle state.
module twt_standby_fsm
    import twt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sby_req,
    input  logic       tmr_en,
    input  logic       wake_any,
    input  logic       settle_wrap,
    output twt_state_e state,
    output logic       entering
);
    twt_state_e state_nx;

    // Accept a standby request only when running and the timer is off.
    assign entering = (state == ST_RUN) && sby_req && !tmr_en;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (entering)    state_nx = ST_SLEEP;
            ST_SLEEP:  if (wake_any)    state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_wrap) state_nx = ST_RUN;
            default:                    state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    assert_refuse_when_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tmr_en) |=> (state == ST_RUN));

    assert_wake_needed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wake_any) |=> (state == ST_SLEEP));

endmodule

// File: rtl/twt_irq_flag.sv
// Module: interrupt pulse register and sticky status flag.
// Behaviour: pulse follows set_evt by one edge; the flag sets with it and
//            clears on clr; set has priority over a simultaneous clear.
// Assumes: set_evt is a single-cycle event.
module twt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic pulse,
    output logic flag
);
    // Register the one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= set_evt;
        end
    end

    // Sticky flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

    assert_flag_falls_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));

endmodule

// File: rtl/tick_wake_timer.sv
// Module: interval timer whose counter doubles as the standby settling timer.
// Behaviour: counts in interval mode and interrupts on each wrap; on standby
//            clears the count, captures the clock select, and after a wake
//            counts one full period before releasing the clock.
// Assumes: control fields come from an external register; outputs are
//          registered or decoded directly from state.
module tick_wake_timer
    import twt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 3,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic              tmr_mode,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              flag_clr,
    input  logic              sby_req,
    input  logic              wake_nmi,
    input  logic [WAKE_W-1:0] wake_irq,
    output logic [CNT_W-1:0]  count_o,
    output logic              int_pulse,
    output logic              int_flag,
    output logic              sby_active,
    output logic              clk_release
);
    twt_state_e       state;
    logic             entering;
    logic             wake_any;
    logic             run;
    logic             tick;
    logic             wrap;
    logic             ivl_wrap;
    logic             settle_wrap;
    logic [SEL_W-1:0] sel_hold;
    logic [SEL_W-1:0] sel_eff;
    logic             rel_q;

    // Any wake line counts as a wake event.
    assign wake_any = wake_nmi || (|wake_irq);

    // Counting runs in interval mode or while settling.
    assign run = ((state == ST_RUN) && tmr_en && !tmr_mode) || (state == ST_SETTLE);

    // Settling uses the captured select, normal running the live one.
    assign sel_eff = (state == ST_RUN) ? clk_sel : sel_hold;

    // Split the counter wrap by the state it happened in.
    assign ivl_wrap    = wrap && (state == ST_RUN);
    assign settle_wrap = wrap && (state == ST_SETTLE);

    // Capture the clock select on standby entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hold <= '0;
        end else if (entering) begin
            sel_hold <= clk_sel;
        end
    end

    // Register the clock-release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= 1'b0;
        end else begin
            rel_q <= settle_wrap;
        end
    end

    twt_standby_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sby_req     (sby_req),
        .tmr_en      (tmr_en),
        .wake_any    (wake_any),
        .settle_wrap (settle_wrap),
        .state       (state),
        .entering    (entering)
    );

    twt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel_eff),
        .tick  (tick)
    );

    twt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (entering),
        .step  (tick),
        .count (count_o),
        .wrap  (wrap)
    );

    twt_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ivl_wrap),
        .clr     (flag_clr),
        .pulse   (int_pulse),
        .flag    (int_flag)
    );

    assign sby_active  = (state != ST_RUN);
    assign clk_release = rel_q;

    assert_release_ends_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clk_release |-> (!sby_active && $past(sby_active)));

    assert_no_irq_from_settle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse |-> !$past(sby_active));

    assert_select_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sby_active && $past(sby_active)) |-> $stable(sel_hold));

    assert_entry_clears_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sby_active) |-> (count_o == '0));

endmodule

// File: tb/tick_wake_timer_test.sv
module tick_wake_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_en = 1'b0;
    logic       tmr_mode = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       flag_clr = 1'b0;
    logic       sby_req = 1'b0;
    logic       wake_nmi = 1'b0;
    logic [3:0] wake_irq = 4'd0;
    logic [7:0] count_o;
    logic       int_pulse;
    logic       int_flag;
    logic       sby_active;
    logic       clk_release;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Scoreboard item: kind 0 = interrupt pulse, kind 1 = clock release.
    typedef struct {
        int    kind;
        int    at;
        string req;
    } evt_t;
    evt_t exp_q[$];

    tick_wake_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_en      (tmr_en),
        .tmr_mode    (tmr_mode),
        .clk_sel     (clk_sel),
        .flag_clr    (flag_clr),
        .sby_req     (sby_req),
        .wake_nmi    (wake_nmi),
        .wake_irq    (wake_irq),
        .count_o     (count_o),
        .int_pulse   (int_pulse),
        .int_flag    (int_flag),
        .sby_active  (sby_active),
        .clk_release (clk_release)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push_evt(input int kind, input int at, input string req);
        evt_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic to_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic observe(input int kind);
        evt_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, (kind == 0) ? "R11" : "R9", "unexpected pulse kind", kind, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, e.req, "pulse kind", kind, e.kind);
            chk(e.at == cyc, e.req, "pulse cycle", cyc, e.at);
        end
    endtask

    // Monitor: compare observed pulses against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (int_pulse)   observe(0);
            if (clk_release) observe(1);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int c, e, f, h, s, w, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(count_o == 8'd0, "R1", "count", count_o, 0);
        chk(!int_pulse && !int_flag, "R1", "irq outputs", {int_pulse, int_flag}, 0);
        chk(!sby_active && !clk_release, "R1", "standby outputs", {sby_active, clk_release}, 0);

        // R2/R3: interval mode, division 2
        @(negedge clk);
        c = cyc;
        clk_sel = 3'd0; tmr_mode = 1'b0; tmr_en = 1'b1;
        push_evt(0, c + 512, "R3");
        push_evt(0, c + 1024, "R4");
        to_cyc(c + 9);
        chk(count_o == 8'd4, "R2", "count before fifth step", count_o, 4);
        to_cyc(c + 10);
        chk(count_o == 8'd5, "R2", "count at fifth step", count_o, 5);
        to_cyc(c + 511);
        chk(count_o == 8'd255 && !int_flag, "R3", "count before wrap", count_o, 255);
        to_cyc(c + 512);
        chk(count_o == 8'd0, "R3", "count at wrap", count_o, 0);
        chk(int_flag, "R4", "flag set at wrap", int_flag, 1);
        to_cyc(c + 520);
        chk(int_flag, "R4", "flag sticky", int_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(!int_flag, "R4", "flag cleared", int_flag, 0);
        // R4 set and clear on the same edge
        to_cyc(c + 1023);
        flag_clr = 1'b1;
        to_cyc(c + 1024);
        flag_clr = 1'b0;
        chk(int_flag, "R4", "set wins over clear", int_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(!int_flag, "R4", "flag cleared after collision", int_flag, 0);

        // R5: disable holds count, re-enable restarts the prescaler
        to_cyc(c + 1044);
        chk(count_o == 8'd10, "R2", "count after second wrap", count_o, 10);
        e = cyc;
        tmr_en = 1'b0;
        to_cyc(e + 50);
        chk(count_o == 8'd10, "R5", "count held while disabled", count_o, 10);
        f = cyc;
        clk_sel = 3'd3; tmr_en = 1'b1;
        to_cyc(f + 15);
        chk(count_o == 8'd10, "R5", "no early step after re-enable", count_o, 10);
        to_cyc(f + 16);
        chk(count_o == 8'd11, "R2", "step after division 16", count_o, 11);
        to_cyc(f + 32);
        chk(count_o == 8'd12, "R2", "second step at division 16", count_o, 12);

        // R6: mode bit 1 holds the count
        tmr_mode = 1'b1;
        to_cyc(f + 132);
        chk(count_o == 8'd12, "R6", "count held in mode 1", count_o, 12);
        tmr_mode = 1'b0; tmr_en = 1'b0;

        // R7: standby refused while enabled
        @(negedge clk);
        h = cyc;
        clk_sel = 3'd0; tmr_en = 1'b1; sby_req = 1'b1;
        @(negedge clk);
        sby_req = 1'b0;
        chk(!sby_active, "R7", "standby refused", sby_active, 0);
        to_cyc(h + 4);
        chk(count_o == 8'd14, "R7", "counting continues", count_o, 14);
        tmr_en = 1'b0;
        // R9: wake outside standby ignored
        wake_nmi = 1'b1;
        @(negedge clk);
        wake_nmi = 1'b0;
        to_cyc(h + 8);
        chk(!sby_active, "R9", "wake outside standby", sby_active, 0);
        chk(count_o == 8'd14, "R9", "count untouched by wake", count_o, 14);

        // R8: standby entry
        s = cyc;
        clk_sel = 3'd1; sby_req = 1'b1;
        @(negedge clk);
        sby_req = 1'b0;
        chk(sby_active, "R8", "standby entered", sby_active, 1);
        chk(count_o == 8'd0, "R8", "count cleared on entry", count_o, 0);
        clk_sel = 3'd7;
        to_cyc(s + 20);
        chk(sby_active && count_o == 8'd0, "R9", "no counting before wake", count_o, 0);
        sby_req = 1'b1;
        @(negedge clk);
        sby_req = 1'b0;
        // R10/R11: wake on IRQ line 2, settle at captured division 4
        w = cyc;
        wake_irq = 4'b0100;
        @(negedge clk);
        wake_irq = 4'd0;
        push_evt(1, w + 1025, "R11");
        to_cyc(w + 13);
        chk(count_o == 8'd3, "R10", "settle uses captured select", count_o, 3);
        to_cyc(w + 1024);
        chk(sby_active, "R10", "still settling before wrap", sby_active, 1);
        to_cyc(w + 1025);
        chk(!sby_active, "R11", "standby ends at wrap", sby_active, 0);
        chk(count_o == 8'd0 && !int_flag, "R11", "no interrupt from settle", int_flag, 0);

        // Second standby, NMI wake, division 2
        to_cyc(w + 1030);
        s2 = cyc;
        clk_sel = 3'd0; sby_req = 1'b1;
        @(negedge clk);
        sby_req = 1'b0;
        wake_nmi = 1'b1;
        @(negedge clk);
        wake_nmi = 1'b0;
        push_evt(1, s2 + 514, "R10");
        to_cyc(s2 + 513);
        chk(sby_active, "R10", "settling with division 2", sby_active, 1);
        to_cyc(s2 + 514);
        chk(!sby_active, "R11", "NMI wake released", sby_active, 0);

        to_cyc(s2 + 530);
        chk(exp_q.size() == 0, "R3", "all expected pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule